// File: doc/BRIEF.md
# Card Host Interrupt Status and Mask Unit

This block holds the interrupt state of a memory-card host controller. It has one 32-bit status word, one 32-bit mask word and a small 16-bit control word for the 32-bit data path, all on a simple register bus. The status word mixes two kinds of bits. Sticky flags latch single-cycle pulses from the command and data engines and edges seen on the card-detect and DAT3 lines. Live bits show the present level of card presence, write protect, DAT3 and command busy.

Software acknowledges a flag by writing 0 to it. Writing 1 leaves the flag as it is, so the usual acknowledge of event X is a write of the inverse of X. A mask bit of 1 blocks its source. A single registered interrupt line is raised when any pending flag is unmasked, or when an enabled flag of the data-path control word is set.

Bus reads are combinational from the address. Writes take effect at the clock edge on which `wr_en` is high.

Top module: `card_irq_ctrl`

## Requirements
- R1: After reset, every status flag is 0. The mask reads 0x8B7F031D, the data-path control word reads 0 and `irq` is 0.
- R2: A write to the status address (addr 0) clears each flag whose data bit is 0 and keeps each flag whose data bit is 1.
- R3: If an event pulse arrives in the same cycle as a write that clears its flag, the flag stays set.
- R4: At the mask address (addr 1), only bit positions 0, 2, 3, 4, 8, 9, 16–22, 24, 25, 27 and 31 can be written. Every other mask bit reads 0.
- R5: A pulse on `evt[i]` sets one status bit at the next clock edge. The mapping is: evt[0]→bit 0 (response end), evt[1]→bit 2 (data end), evt[8:2]→bits 22:16 (index error, CRC fail, end-bit error, data timeout, RX overflow, TX underrun, response timeout, in that order), evt[9]→bit 24, evt[10]→bit 25, evt[11]→bit 31 (illegal access).
- R6: Status bit 5 shows the card-detect level, bit 7 shows write protect and bit 10 shows DAT3. Each of these follows its input after two clock edges and is not changed by writes. Bit 30 shows `cmd_busy` and bit 29 shows its inverse.
- R7: A rising card-detect edge sets bit 4 and a falling one sets bit 3. A falling DAT3 edge sets bit 8 and a rising one sets bit 9. Each of these flags is set at the third clock edge after the input changes.
- R8: Status bits 1, 6, 11–15, 23, 26, 27 and 28 always read 0.
- R9: `irq` rises one clock edge after an unmasked flag is set. It falls one edge after that flag is masked or cleared.
- R10: In the control word (addr 2), bit 1 selects 32-bit mode, bit 11 enables the RX-ready interrupt and bit 12 enables the busy interrupt. Bit 8 latches `d32_rx` pulses and bit 9 latches `d32_busy` pulses, but only while bit 1 is already 1. Writing 1 to bit 10 clears bits 8 and 9, and bit 10 always reads 0.
- R11: `irq` is also raised when control bit 8 is set with bit 11 set, or when bit 9 is set with bit 12 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register select: 0 status, 1 mask, 2 data-path control |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| evt | input | 12 | Single-cycle event and error pulses |
| cmd_busy | input | 1 | Command engine busy level |
| card_det | input | 1 | Asynchronous card-detect line |
| wr_prot | input | 1 | Asynchronous write-protect line |
| dat3 | input | 1 | Asynchronous DAT3 detect line |
| d32_rx | input | 1 | 32-bit path RX-ready pulse |
| d32_busy | input | 1 | 32-bit path busy pulse |
| irq | output | 1 | Registered interrupt request |

## Verification
A flag that is lost, stuck or set by the wrong source shows up in the next status read, one edge after the pulse. It also shows on `irq` one edge later once the mask is opened. A synchronizer or edge detector with the wrong depth moves the live bit or the event flag off its exact cycle, so the bench samples at that cycle. A fault in the write-zero rule or in event priority leaves a neighbouring flag wrong after a partial acknowledge, and this is visible in the very next read.

// File: rtl/card_irq_ctrl.sv
module card_irq_ctrl #(
  parameter int AW = 2,
  parameter logic [AW-1:0] A_STAT = 0,
  parameter logic [AW-1:0] A_MASK = 1,
  parameter logic [AW-1:0] A_D32 = 2,
  parameter logic [31:0] MASK_W = 32'h8B7F031D,
  parameter int NEV = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic [NEV-1:0] evt,
  input  logic          cmd_busy,
  input  logic          card_det,
  input  logic          wr_prot,
  input  logic          dat3,
  input  logic          d32_rx,
  input  logic          d32_busy,
  output logic          irq
);
  localparam logic [31:0] FLAG_BITS = 32'h837F031D;

  logic [31:0] flags, mask, ev_set, stat_rd;
  logic [2:0]  s1, s2, sq;
  logic        mode, en_rx, en_busy;
  logic [1:0]  d32f;
  logic        st_wr, mk_wr, dc_wr;

  assign st_wr = wr_en && addr == A_STAT;
  assign mk_wr = wr_en && addr == A_MASK;
  assign dc_wr = wr_en && addr == A_D32;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; sq <= '0;
    end else begin
      s1 <= {dat3, wr_prot, card_det};
      s2 <= s1;
      sq <= s2;
    end
  end

  always_comb begin
    ev_set        = '0;
    ev_set[0]     = evt[0];
    ev_set[2]     = evt[1];
    ev_set[22:16] = evt[8:2];
    ev_set[24]    = evt[9];
    ev_set[25]    = evt[10];
    ev_set[31]    = evt[11];
    ev_set[3]     = sq[0] & ~s2[0];
    ev_set[4]     = s2[0] & ~sq[0];
    ev_set[8]     = sq[2] & ~s2[2];
    ev_set[9]     = s2[2] & ~sq[2];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags <= '0;
      mask  <= MASK_W;
    end else begin
      flags <= ((st_wr ? (flags & wdata) : flags) | ev_set) & FLAG_BITS;
      if (mk_wr) mask <= wdata & MASK_W;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= 1'b0; en_rx <= 1'b0; en_busy <= 1'b0; d32f <= '0;
    end else begin
      if (dc_wr) begin
        mode    <= wdata[1];
        en_rx   <= wdata[11];
        en_busy <= wdata[12];
      end
      d32f <= ((dc_wr && wdata[10]) ? 2'b00 : d32f) | ({d32_busy, d32_rx} & {2{mode}});
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= (|(flags & ~mask)) | (d32f[0] & en_rx) | (d32f[1] & en_busy);
  end

  always_comb begin
    stat_rd     = flags;
    stat_rd[5]  = s2[0];
    stat_rd[7]  = s2[1];
    stat_rd[10] = s2[2];
    stat_rd[29] = ~cmd_busy;
    stat_rd[30] = cmd_busy;
  end

  always_comb begin
    case (addr)
      A_STAT:  rdata = stat_rd;
      A_MASK:  rdata = mask;
      A_D32:   rdata = {16'h0, 3'b000, en_busy, en_rx, 1'b0, d32f, 6'b0, mode, 1'b0};
      default: rdata = '0;
    endcase
  end

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(st_wr) |-> ((flags & $past(flags)) == $past(flags))); // R2
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(evt[0]) |-> flags[0]); // R3
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_STAT) |-> ((rdata & 32'h1C80F842) == 0)); // R8
  AST_BUSY_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_STAT) |-> (rdata[29] != rdata[30])); // R6
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past((|(flags & ~mask)) || (d32f[0] && en_rx) || (d32f[1] && en_busy))); // R9
  AST_D32_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mode) |-> ((d32f & ~$past(d32f)) == 2'b00)); // R10
endmodule

// File: tb/card_irq_ctrl_test.sv
module card_irq_ctrl_test;
  localparam int CLK_P = 10;
  localparam logic [31:0] LIVE0 = 32'h2000_0000;
  localparam logic [31:0] EXP [12] = '{
    32'h0000_0001, 32'h0000_0004, 32'h0001_0000, 32'h0002_0000,
    32'h0004_0000, 32'h0008_0000, 32'h0010_0000, 32'h0020_0000,
    32'h0040_0000, 32'h0100_0000, 32'h0200_0000, 32'h8000_0000};

  logic clk = 0, rst_n = 0, wr_en = 0, cmd_busy = 0;
  logic card_det = 0, wr_prot = 0, dat3 = 0, d32_rx = 0, d32_busy = 0;
  logic [1:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic [11:0] evt = 0;
  logic irq;
  int nchk = 0, nfail = 0;
  bit done = 0;

  card_irq_ctrl uut (.clk, .rst_n, .addr, .wr_en, .wdata, .rdata, .evt, .cmd_busy,
    .card_det, .wr_prot, .dat3, .d32_rx, .d32_busy, .irq);

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse(input logic [11:0] e);
    @(negedge clk); evt = e;
    @(negedge clk); evt = 0;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(0, v); chk("R1 status", v, LIVE0);
    rd(1, v); chk("R1 mask", v, 32'h8B7F031D);
    rd(2, v); chk("R1 ctrl", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    for (int i = 0; i < 12; i++) begin
      pulse(12'(1) << i);
      rd(0, v); chk("R5 set", v, EXP[i] | LIVE0);
      wr(0, ~EXP[i]);
      rd(0, v); chk("R2 ack", v, LIVE0);
    end

    wr(1, 32'hFFFF_FFFF);
    rd(1, v); chk("R4 mask ones", v, 32'h8B7F031D);
    wr(1, 32'h0);
    rd(1, v); chk("R4 mask zero", v, 0);

    pulse(12'h003);
    wr(0, ~32'h1);
    rd(0, v); chk("R2 partial", v, LIVE0 | 32'h4);
    wr(0, 0);

    @(negedge clk); addr = 0; wdata = 0; wr_en = 1; evt = 12'h001;
    @(negedge clk); wr_en = 0; evt = 0;
    rd(0, v); chk("R3 event wins", v, LIVE0 | 32'h1);
    chk("R9 irq not yet", {31'b0, irq}, 0);
    @(negedge clk);
    chk("R9 irq raised", {31'b0, irq}, 1);
    wr(1, 32'h1);
    @(negedge clk);
    chk("R9 irq masked", {31'b0, irq}, 0);
    wr(0, 0);
    wr(1, MASK_ALL());

    @(negedge clk); card_det = 1; wr_prot = 1;
    @(negedge clk); @(negedge clk);
    rd(0, v); chk("R6 live sync", v, LIVE0 | 32'hA0);
    @(negedge clk);
    rd(0, v); chk("R7 insert", v, LIVE0 | 32'hB0);
    wr(0, 0);
    rd(0, v); chk("R6 live unwritable", v, LIVE0 | 32'hA0);
    card_det = 0; wr_prot = 0; cmd_busy = 1;
    repeat (3) @(negedge clk);
    rd(0, v); chk("R7 remove", v, 32'h4000_0008);
    cmd_busy = 0; wr(0, 0);

    dat3 = 1;
    repeat (3) @(negedge clk);
    rd(0, v); chk("R7 dat3 rise", v, LIVE0 | 32'h600);
    dat3 = 0;
    repeat (3) @(negedge clk);
    rd(0, v); chk("R7 dat3 fall", v, LIVE0 | 32'h300);
    wr(0, 32'hFFFF_FFFF);
    rd(0, v); chk("R8 reserved", v & 32'h1C80F842, 0);
    wr(0, 0);

    @(negedge clk); d32_rx = 1; d32_busy = 1;
    @(negedge clk); d32_rx = 0; d32_busy = 0;
    rd(2, v); chk("R10 gated", v, 0);
    wr(2, 32'h0802);
    @(negedge clk); d32_rx = 1;
    @(negedge clk); d32_rx = 0;
    rd(2, v); chk("R10 rx flag", v, 32'h0902);
    @(negedge clk);
    chk("R11 irq rx", {31'b0, irq}, 1);
    @(negedge clk); d32_busy = 1;
    @(negedge clk); d32_busy = 0;
    rd(2, v); chk("R10 busy flag", v, 32'h0B02);
    wr(2, 32'h0402);
    rd(2, v); chk("R10 clear", v, 32'h0002);
    @(negedge clk);
    chk("R11 irq drop", {31'b0, irq}, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  function automatic logic [31:0] MASK_ALL();
    return 32'h8B7F031D;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule